// File: doc/BRIEF.md
# Move-Only Transport Processor

This block is a sequencer with a single operation. Each instruction moves one data word from a source address to a destination address inside a shared, partitioned 8-bit address space. Nothing in the sequencer computes. All arithmetic is done by processing elements (PEs) whose input and output registers appear as cells in that space. Around the mapped PE the space holds these sections:

- a read-only constant section;
- a RAM section that tracks, per word, whether the word has been written;
- a cyclic buffer reached through one address;
- an input port and an output port to the outside.

A program is written into the instruction memory through a load port and then runs in an endless loop. Each instruction may carry a condition. When the condition is enabled, the move happens only if the word at a third address is nonzero, so data flows between PEs only when the program allows it. The example PE is a two-input adder.

Top module: `move_engine`

## Requirements
- R1: An instruction is 25 bits, laid out as {condEn[24], condAddr[23:16], srcAddr[15:8], dstAddr[7:0]}. Its only effect is to copy the word read at srcAddr into the cell at dstAddr.
- R2: Each instruction takes two clock cycles, a read cycle followed by a write cycle. The effect of the k-th instruction after reset is visible after rising edge 2k+2. pcOut holds the slot of the current instruction and wraps from PROG_DEPTH-1 to 0.
- R3: When condEn is 1 and the word at condAddr is zero, the instruction changes nothing. When the word is nonzero, the move takes place. Reading condAddr has no side effect, even when it points at the cyclic buffer.
- R4: Addresses 0x00 to 0x0F read the constants 5*i+3, where i is the offset. A move into this range leaves the constants unchanged and raises romErr for exactly one cycle.
- R5: Addresses 0x10 to 0x1F are RAM words. Reading a word that has not been written since reset returns 0.
- R6: Address 0x20 is a cyclic buffer of CYC_DEPTH entries (4 by default). A move from it returns the entry at the read pointer and then advances that pointer. A move into it stores at the write pointer and then advances that pointer. Both pointers wrap modulo CYC_DEPTH.
- R7: Addresses 0x30 and 0x31 are the adder inputs, and 0x32 is its sum, taken modulo 2^DATA_W. The sum cell updates one cycle after either input is written. The instruction that immediately follows such a write therefore reads the previous sum, and the instruction after that reads the new sum.
- R8: A move from 0x40 takes inData as sampled in the read cycle. A move into 0x41 sets outData and raises outValid for exactly one cycle.
- R9: While halt is high, the program counter and the phase are frozen and no move takes place. When halt is released, the interrupted instruction resumes with the word it has already read.
- R10: A synchronous reset returns the block to its start state and leaves the loaded program in place. The start state is: pcOut at 0, every RAM word marked unwritten, both cyclic pointers and the buffer entries cleared, the adder registers at 0, and outData, outValid and romErr at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halt | input | 1 | Freezes the sequencer while high |
| progWe | input | 1 | Write strobe of the instruction memory |
| progAddr | input | $clog2(PROG_DEPTH) | Instruction slot to write |
| progData | input | 25 | Instruction word to write |
| inData | input | DATA_W | Value returned by reads of the input port |
| outData | output | DATA_W | Last word moved to the output port |
| outValid | output | 1 | One-cycle pulse when the output port is written |
| romErr | output | 1 | One-cycle pulse when a move targets the constant section |
| pcOut | output | $clog2(PROG_DEPTH) | Current program slot |

## Verification
Any wrong state inside the block reaches the output port within at most one loop of the program, because the test program routes every section to that port. A pointer that slips in the cyclic buffer changes the next popped word. A RAM word wrongly marked as written shows stale data instead of 0. A sum that updates too early breaks the expected stale value in the hazard slot. A phase or program-counter error shifts the outValid pulses away from even edges and shows on pcOut at once. The adder is swept over zero, the all-ones word and spread values to cover wrap-around. A halt in the middle of an instruction and a reset in the middle of a pass show whether the state is kept or cleared as required.

// File: rtl/move_pkg.sv
package move_pkg;

  localparam int ADDR_W    = 8;
  localparam int INSTR_W   = 1 + 3 * ADDR_W;
  localparam int ROM_WORDS = 16;
  localparam int RAM_WORDS = 16;
  localparam int ROM_IDX_W = $clog2(ROM_WORDS);
  localparam int RAM_IDX_W = $clog2(RAM_WORDS);

  localparam logic [ADDR_W-1:0] ROM_BASE = 8'h00;
  localparam logic [ADDR_W-1:0] ROM_LAST = 8'h0F;
  localparam logic [ADDR_W-1:0] RAM_BASE = 8'h10;
  localparam logic [ADDR_W-1:0] RAM_LAST = 8'h1F;
  localparam logic [ADDR_W-1:0] CYC_ADDR = 8'h20;
  localparam logic [ADDR_W-1:0] PEA_ADDR = 8'h30;
  localparam logic [ADDR_W-1:0] PEB_ADDR = 8'h31;
  localparam logic [ADDR_W-1:0] SUM_ADDR = 8'h32;
  localparam logic [ADDR_W-1:0] IN_ADDR  = 8'h40;
  localparam logic [ADDR_W-1:0] OUT_ADDR = 8'h41;

  typedef enum logic [3:0] {
    SEC_NONE, SEC_ROM, SEC_RAM, SEC_CYC, SEC_PEA, SEC_PEB, SEC_SUM, SEC_IN, SEC_OUT
  } sec_e;

  typedef struct packed {
    logic              rdEn;
    logic              wrEn;
    logic [ADDR_W-1:0] condAddr;
    logic [ADDR_W-1:0] srcAddr;
    logic [ADDR_W-1:0] dstAddr;
  } strobe_t;

  function automatic sec_e decodeSec(input logic [ADDR_W-1:0] a);
    sec_e s;
    if (a >= ROM_BASE && a <= ROM_LAST)      s = SEC_ROM;
    else if (a >= RAM_BASE && a <= RAM_LAST) s = SEC_RAM;
    else if (a == CYC_ADDR)                  s = SEC_CYC;
    else if (a == PEA_ADDR)                  s = SEC_PEA;
    else if (a == PEB_ADDR)                  s = SEC_PEB;
    else if (a == SUM_ADDR)                  s = SEC_SUM;
    else if (a == IN_ADDR)                   s = SEC_IN;
    else if (a == OUT_ADDR)                  s = SEC_OUT;
    else                                     s = SEC_NONE;
    return s;
  endfunction

endpackage

// File: rtl/move_ctrl.sv
module move_ctrl import move_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int PROG_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          halt,
  input  logic                          progWe,
  input  logic [$clog2(PROG_DEPTH)-1:0] progAddr,
  input  logic [INSTR_W-1:0]            progData,
  input  logic [DATA_W-1:0]             condWord,
  output strobe_t                       strb,
  output logic [$clog2(PROG_DEPTH)-1:0] pc
);

  localparam int PC_W = $clog2(PROG_DEPTH);
  localparam logic [PC_W-1:0] LAST_SLOT = PC_W'(PROG_DEPTH - 1);

  typedef enum logic {PH_READ, PH_WRITE} phase_e;

  logic [INSTR_W-1:0] imem [PROG_DEPTH];
  logic [INSTR_W-1:0] instr;
  phase_e             phase;
  logic               goReg;
  logic               condEn;
  logic               go;

  always_ff @(posedge clk) begin
    if (progWe) imem[progAddr] <= progData;
  end

  assign instr  = imem[pc];
  assign condEn = instr[INSTR_W-1];
  assign go     = !condEn || (condWord != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      phase <= PH_READ;
      goReg <= 1'b0;
    end else if (!halt) begin
      if (phase == PH_READ) begin
        goReg <= go;
        phase <= PH_WRITE;
      end else begin
        phase <= PH_READ;
        pc    <= (pc == LAST_SLOT) ? '0 : pc + 1'b1;
      end
    end
  end

  always_comb begin
    strb.rdEn     = !halt && (phase == PH_READ) && go;
    strb.wrEn     = !halt && (phase == PH_WRITE) && goReg;
    strb.condAddr = instr[3*ADDR_W-1:2*ADDR_W];
    strb.srcAddr  = instr[2*ADDR_W-1:ADDR_W];
    strb.dstAddr  = instr[ADDR_W-1:0];
  end

  // R2: after an unhalted write cycle the slot advances by one, wrapping at the end
  p_pc_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (!halt && phase == PH_WRITE) |=>
      (pc == (($past(pc) == LAST_SLOT) ? '0 : $past(pc) + 1'b1)));

  // R2: read and write strobes never coincide
  p_one_phase_r2: assert property (@(posedge clk) disable iff (rst)
    !(strb.rdEn && strb.wrEn));

  // R9: halt freezes the sequencer
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    halt |=> ($stable(pc) && $stable(phase)));

endmodule

// File: rtl/move_dp.sv
module move_dp import move_pkg::*; #(
  parameter int DATA_W    = 16,
  parameter int CYC_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] condWord,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              romErr
);

  localparam int CYC_PTR_W = (CYC_DEPTH > 1) ? $clog2(CYC_DEPTH) : 1;
  localparam logic [CYC_PTR_W-1:0] CYC_LAST = CYC_PTR_W'(CYC_DEPTH - 1);

  logic [DATA_W-1:0]    ramMem [RAM_WORDS];
  logic [RAM_WORDS-1:0] ramValid;
  logic [DATA_W-1:0]    cycMem [CYC_DEPTH];
  logic [CYC_PTR_W-1:0] rdPtr, wrPtr;
  logic [DATA_W-1:0]    peA, peB, peSum;
  logic                 peWrote;
  logic [DATA_W-1:0]    moveData;
  logic [DATA_W-1:0]    srcWord;
  sec_e                 srcSec, dstSec;
  logic [RAM_IDX_W-1:0] srcRamIdx, dstRamIdx;

  function automatic logic [CYC_PTR_W-1:0] nextPtr(input logic [CYC_PTR_W-1:0] p);
    return (p == CYC_LAST) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] romWord(input logic [ROM_IDX_W-1:0] i);
    return DATA_W'(5 * int'(i) + 3);
  endfunction

  function automatic logic [DATA_W-1:0] peek(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0]    w;
    logic [RAM_IDX_W-1:0] ri;
    ri = RAM_IDX_W'(a - RAM_BASE);
    case (decodeSec(a))
      SEC_ROM: w = romWord(ROM_IDX_W'(a - ROM_BASE));
      SEC_RAM: w = ramValid[ri] ? ramMem[ri] : '0;
      SEC_CYC: w = cycMem[rdPtr];
      SEC_PEA: w = peA;
      SEC_PEB: w = peB;
      SEC_SUM: w = peSum;
      SEC_IN:  w = inData;
      SEC_OUT: w = outData;
      default: w = '0;
    endcase
    return w;
  endfunction

  assign srcSec    = decodeSec(strb.srcAddr);
  assign dstSec    = decodeSec(strb.dstAddr);
  assign srcRamIdx = RAM_IDX_W'(strb.srcAddr - RAM_BASE);
  assign dstRamIdx = RAM_IDX_W'(strb.dstAddr - RAM_BASE);
  assign condWord  = peek(strb.condAddr);
  assign srcWord   = peek(strb.srcAddr);

  always_ff @(posedge clk) begin
    if (!rst && strb.wrEn && dstSec == SEC_RAM) ramMem[dstRamIdx] <= moveData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ramValid <= '0;
      rdPtr    <= '0;
      wrPtr    <= '0;
      for (int i = 0; i < CYC_DEPTH; i++) cycMem[i] <= '0;
      peA      <= '0;
      peB      <= '0;
      peSum    <= '0;
      peWrote  <= 1'b0;
      moveData <= '0;
      outData  <= '0;
      outValid <= 1'b0;
      romErr   <= 1'b0;
    end else begin
      outValid <= 1'b0;
      romErr   <= 1'b0;
      peWrote  <= 1'b0;
      if (peWrote) peSum <= peA + peB;
      if (strb.rdEn) begin
        moveData <= srcWord;
        if (srcSec == SEC_CYC) rdPtr <= nextPtr(rdPtr);
      end
      if (strb.wrEn) begin
        case (dstSec)
          SEC_ROM: romErr <= 1'b1;
          SEC_RAM: ramValid[dstRamIdx] <= 1'b1;
          SEC_CYC: begin
            cycMem[wrPtr] <= moveData;
            wrPtr         <= nextPtr(wrPtr);
          end
          SEC_PEA: begin
            peA     <= moveData;
            peWrote <= 1'b1;
          end
          SEC_PEB: begin
            peB     <= moveData;
            peWrote <= 1'b1;
          end
          SEC_OUT: begin
            outData  <= moveData;
            outValid <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R7: one cycle after an input write the sum cell holds the sum of both inputs
  p_sum_follow_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && (dstSec == SEC_PEA || dstSec == SEC_PEB)) |=> ##1 (peSum == peA + peB));

  // R4: the constant-write flag is a single-cycle pulse
  p_rom_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    romErr |=> !romErr);

  // R8: the output strobe lasts one cycle
  p_out_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R6: the read pointer only ever steps by one position, modulo the depth
  p_cyc_step_r6: assert property (@(posedge clk) disable iff (rst)
    (rdPtr != $past(rdPtr)) |-> (rdPtr == nextPtr($past(rdPtr))));

  // R5: an unwritten RAM word is read as zero
  p_ram_blank_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.rdEn && srcSec == SEC_RAM && !ramValid[srcRamIdx]) |=> (moveData == '0));

endmodule

// File: rtl/move_engine.sv
module move_engine import move_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int PROG_DEPTH = 16,
  parameter int CYC_DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          halt,
  input  logic                          progWe,
  input  logic [$clog2(PROG_DEPTH)-1:0] progAddr,
  input  logic [INSTR_W-1:0]            progData,
  input  logic [DATA_W-1:0]             inData,
  output logic [DATA_W-1:0]             outData,
  output logic                          outValid,
  output logic                          romErr,
  output logic [$clog2(PROG_DEPTH)-1:0] pcOut
);

  strobe_t           strb;
  logic [DATA_W-1:0] condWord;

  move_ctrl #(.DATA_W(DATA_W), .PROG_DEPTH(PROG_DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .halt     (halt),
    .progWe   (progWe),
    .progAddr (progAddr),
    .progData (progData),
    .condWord (condWord),
    .strb     (strb),
    .pc       (pcOut)
  );

  move_dp #(.DATA_W(DATA_W), .CYC_DEPTH(CYC_DEPTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inData   (inData),
    .condWord (condWord),
    .outData  (outData),
    .outValid (outValid),
    .romErr   (romErr)
  );

endmodule

// File: tb/test_move_engine.sv
module test_move_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        halt = 1'b0;
  logic        progWe = 1'b0;
  logic [3:0]  progAddr = '0;
  logic [24:0] progData = '0;
  logic [15:0] inData = '0;
  logic [15:0] outData;
  logic        outValid;
  logic        romErr;
  logic [3:0]  pcOut;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  logic [24:0] prog [DEPTH];

  // model state, derived from the requirements
  logic [15:0] mRam [16];
  bit          mValid [16];
  logic [15:0] mCyc [4];
  int          mRp, mWp;
  logic [15:0] mA, mB, mSum, mMove, mOut;
  bit          mPend, mGo;
  int          n;
  int          passIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  move_engine i_move_engine (
    .clk(clk), .rst(rst), .halt(halt), .progWe(progWe), .progAddr(progAddr),
    .progData(progData), .inData(inData), .outData(outData), .outValid(outValid),
    .romErr(romErr), .pcOut(pcOut)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [24:0] enc(input bit ce, input logic [7:0] c,
                                      input logic [7:0] s, input logic [7:0] d);
    return {ce, c, s, d};
  endfunction

  function automatic logic [15:0] passValue(input int p);
    if (p == 1) return 16'h0000;
    if (p == 3) return 16'hFFFF;
    return 16'((p + 1) * 4951);
  endfunction

  function automatic string slotTag(input int s);
    case (s)
      0, 1:            return "R1";
      2, 3:            return "R5";
      4, 5, 6, 7:      return "R7";
      8, 9:            return "R4";
      13, 14:          return "R3";
      default:         return "R6";
    endcase
  endfunction

  function automatic logic [15:0] peekM(input logic [7:0] a);
    if (a <= 8'h0F) return 16'(5 * int'(a) + 3);
    if (a <= 8'h1F) return mValid[a - 8'h10] ? mRam[a - 8'h10] : 16'h0;
    case (a)
      8'h20:   return mCyc[mRp];
      8'h30:   return mA;
      8'h31:   return mB;
      8'h32:   return mSum;
      8'h40:   return inData;
      8'h41:   return mOut;
      default: return 16'h0;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 16; i++) mValid[i] = 1'b0;
    for (int i = 0; i < 4; i++) mCyc[i] = '0;
    mRp = 0; mWp = 0;
    mA = '0; mB = '0; mSum = '0; mMove = '0; mOut = '0;
    mPend = 1'b0; mGo = 1'b0;
  endtask

  task automatic modelRead(input int slot);
    logic [24:0] w;
    w = prog[slot];
    mGo = !w[24] || (peekM(w[23:16]) != 16'h0);
    if (mGo) begin
      mMove = peekM(w[15:8]);
      if (w[15:8] == 8'h20) mRp = (mRp + 1) % 4;
    end
    if (mPend) begin
      mSum  = mA + mB;
      mPend = 1'b0;
    end
  endtask

  task automatic modelWrite(input int slot, output bit expV, output bit expE);
    logic [7:0] d;
    d = prog[slot][7:0];
    expV = 1'b0;
    expE = 1'b0;
    if (mGo) begin
      if (d <= 8'h0F) expE = 1'b1;
      else if (d <= 8'h1F) begin
        mRam[d - 8'h10]   = mMove;
        mValid[d - 8'h10] = 1'b1;
      end else if (d == 8'h20) begin
        mCyc[mWp] = mMove;
        mWp = (mWp + 1) % 4;
      end else if (d == 8'h30) begin
        mA = mMove; mPend = 1'b1;
      end else if (d == 8'h31) begin
        mB = mMove; mPend = 1'b1;
      end else if (d == 8'h41) begin
        mOut = mMove; expV = 1'b1;
      end
    end
  endtask

  // runs a number of unhalted edges; haltAt gives the edge after which halt is held
  task automatic runEdges(input int count, input int haltAt, input int haltLen);
    int  done = 0;
    int  haltLeft = 0;
    int  heldPc = 0;
    bit  expV, expE;
    int  k, slot;
    while (done < count) begin
      halt = (haltLeft > 0);
      @(posedge clk);
      @(negedge clk);
      if (halt) begin
        check(pcOut == 4'(heldPc), "R9", "pc held during halt", pcOut, heldPc);
        check(outValid == 1'b0, "R9", "no move during halt", outValid, 0);
        haltLeft--;
      end else begin
        n++;
        done++;
        if (n % 2 == 1) begin
          k = (n - 1) / 2;
          slot = k % DEPTH;
          modelRead(slot);
          check(pcOut == 4'(slot), "R2", "pc in read cycle", pcOut, slot);
          check(outValid == 1'b0, "R8", "no strobe after read edge", outValid, 0);
        end else begin
          k = n / 2 - 1;
          slot = k % DEPTH;
          modelWrite(slot, expV, expE);
          check(outValid == expV, slotTag(slot), "outValid", outValid, expV);
          check(outData == mOut, slotTag(slot), "outData", outData, mOut);
          check(romErr == expE, "R4", "romErr", romErr, expE);
          check(pcOut == 4'((slot + 1) % DEPTH), "R2", "pc after write", pcOut, (slot + 1) % DEPTH);
          if (n % 32 == 0) begin
            inData = passValue(passIdx);
            passIdx++;
          end
        end
        if (n == haltAt) begin
          haltLeft = haltLen;
          heldPc = pcOut;
        end
      end
    end
    halt = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    prog[0]  = enc(0, 8'h00, 8'h02, 8'h10);
    prog[1]  = enc(0, 8'h00, 8'h10, 8'h41);
    prog[2]  = enc(0, 8'h00, 8'h11, 8'h41);
    prog[3]  = enc(0, 8'h00, 8'h40, 8'h11);
    prog[4]  = enc(0, 8'h00, 8'h40, 8'h30);
    prog[5]  = enc(0, 8'h00, 8'h05, 8'h31);
    prog[6]  = enc(0, 8'h00, 8'h32, 8'h41);
    prog[7]  = enc(0, 8'h00, 8'h32, 8'h41);
    prog[8]  = enc(0, 8'h00, 8'h00, 8'h01);
    prog[9]  = enc(0, 8'h00, 8'h01, 8'h41);
    prog[10] = enc(0, 8'h00, 8'h40, 8'h20);
    prog[11] = enc(0, 8'h00, 8'h07, 8'h20);
    prog[12] = enc(0, 8'h00, 8'h20, 8'h41);
    prog[13] = enc(1, 8'h12, 8'h03, 8'h41);
    prog[14] = enc(1, 8'h40, 8'h04, 8'h41);
    prog[15] = enc(1, 8'h20, 8'h20, 8'h41);

    // load the program while reset is held
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) begin
      progWe   = 1'b1;
      progAddr = 4'(i);
      progData = prog[i];
      @(negedge clk);
    end
    progWe = 1'b0;
    @(negedge clk);
    check(pcOut == 4'd0, "R10", "pc in reset", pcOut, 0);
    check(outValid == 1'b0, "R10", "outValid in reset", outValid, 0);
    check(romErr == 1'b0, "R10", "romErr in reset", romErr, 0);
    check(outData == 16'h0, "R10", "outData in reset", outData, 0);

    modelReset();
    n = 0;
    passIdx = 0;
    inData = passValue(passIdx);
    passIdx++;
    rst = 1'b0;

    // four passes, halted for five cycles after the read of slot 12 in pass 2
    runEdges(4 * 2 * DEPTH, 2 * (2 * DEPTH + 12) + 1, 5);
    // part of a fifth pass, then a reset in the middle of it
    runEdges(2 * 5, -1, 0);

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(pcOut == 4'd0, "R10", "pc after mid-run reset", pcOut, 0);
    check(outValid == 1'b0, "R10", "outValid after mid-run reset", outValid, 0);
    check(outData == 16'h0, "R10", "outData after mid-run reset", outData, 0);
    modelReset();
    n = 0;
    inData = passValue(passIdx);
    passIdx++;
    rst = 1'b0;

    // four more passes from the reset state, with the program kept
    runEdges(4 * 2 * DEPTH, -1, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule